// File: doc/BRIEF.md
# Tearing-Effect Sync Trigger

This block sits between a display panel's tearing-effect output and the pixel packer that feeds the panel. The panel drives a single wire with two kinds of pulses: short ones once per scan line and a longer one once per frame. The block measures the width of each pulse in clock ticks. It decides from two programmed widths whether a pulse was a line pulse, a frame pulse or a glitch. It then issues a one-cycle start strobe that lets the packer begin writing a frame without tearing.

Three trigger sources are available. With the internal source the strobe follows the enable at once. In the frame-pulse mode the strobe follows the first qualified frame pulse. In the line mode the block counts line pulses after a frame pulse and fires when the count reaches a programmed line number. Each active pulse level can be inverted on its own. One strobe is issued per enable, and dropping the enable throws away any trigger still waiting.

Top module: `te_sync_trigger`

## Requirements
- R1: While reset is held, and on the first sample after it is released, `startStrobe` is 0.
- R2: With `trigMode` = 0 (internal), `startStrobe` is 1 for the cycle after the first clock edge that samples `xferEn` high.
- R3: A run of consecutive samples of `teIn` at the frame-pulse active level is a frame pulse when its length is at least `vsWidth`. A run at the line-pulse active level is a line pulse when its length is at least `hsWidth` and below `vsWidth`. Shorter runs cause no effect. Run lengths saturate at the counter maximum, and a saturated run still qualifies.
- R4: With `trigMode` = 1, a frame pulse fires the strobe and line pulses do not. The strobe is high in the cycle after the second clock edge following the first edge that samples `teIn` back at the inactive level.
- R5: With `trigMode` = 2, line pulses are counted after a frame pulse. The strobe fires when the count equals `lineNum`, with the R4 latency measured from the end of that line pulse. When `lineNum` = 0 it fires at the end of the frame pulse itself.
- R6: In `trigMode` = 2, line pulses count only after a frame pulse seen while `xferEn` is high. Every further frame pulse restarts the count at zero.
- R7: At most one strobe is issued per enable, and each strobe lasts exactly one cycle. Lowering `xferEn` and raising it again allows a new strobe.
- R8: A clock edge that samples `xferEn` low clears any pending trigger, the line count and the seen-frame state. The strobe is never high after an edge that sampled `xferEn` low.
- R9: `vsPolDef` = 1 makes the frame-pulse active level high and 0 makes it low. `hsPolDef` works the same way for line pulses.
- R10: `trigMode` = 3 is reserved and never produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; widths are counted in its ticks |
| rstN | input | 1 | Asynchronous active-low reset |
| teIn | input | 1 | Tearing-effect wire from the panel |
| vsPolDef | input | 1 | 1: frame pulse active high, 0: active low |
| hsPolDef | input | 1 | 1: line pulse active high, 0: active low |
| trigMode | input | 2 | 0 internal, 1 frame pulse, 2 frame pulse plus line count, 3 reserved |
| hsWidth | input | CNT_W | Minimum line-pulse width in ticks (at least 2) |
| vsWidth | input | CNT_W | Minimum frame-pulse width in ticks (differs from hsWidth) |
| lineNum | input | LINE_W | Line count after the frame pulse at which to start (0 to 2047) |
| xferEn | input | 1 | Transfer request; low cancels |
| startStrobe | output | 1 | One-cycle start pulse to the pixel packer |

## Verification
The bench builds the block with a 5-bit width counter and the default 11-bit line number. The small counter lets a frame pulse of 40 ticks against a programmed width of 31 exercise saturation in a short run. Random trials in line mode draw widths, line numbers and pulse lengths inside and just below each class, and place glitches between line pulses. Directed cases cover the exact-width boundary, the line-zero case, restarts on a new frame pulse, cancellation, inverted polarity and the reserved mode.

// File: rtl/te_sync_pkg.sv
`timescale 1ns/1ps
package te_sync_pkg;

  typedef enum logic [1:0] {
    TRIG_INTERNAL = 2'd0,
    TRIG_FRAME    = 2'd1,
    TRIG_LINE     = 2'd2,
    TRIG_RESERVED = 2'd3
  } trigSel_e;

  // classified pulse strobes from the measuring datapath to the control
  typedef struct packed {
    logic vsEvt;
    logic hsEvt;
  } teEvt_t;

endpackage

// File: rtl/te_pulse_meas.sv
`timescale 1ns/1ps
module te_pulse_meas
  import te_sync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             teIn,
  input  logic             vsPolDef,
  input  logic             hsPolDef,
  input  logic [CNT_W-1:0] hsWidth,
  input  logic [CNT_W-1:0] vsWidth,
  output teEvt_t           evt
);

  localparam int NCH   = 2;
  localparam int CH_VS = 0;
  localparam int CH_HS = 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                       teQ;
  logic [NCH-1:0]             actLvl;
  logic [NCH-1:0][CNT_W-1:0]  runLen;
  logic [NCH-1:0]             pulseEnd;

  assign actLvl[CH_VS] = vsPolDef;
  assign actLvl[CH_HS] = hsPolDef;

  // input sampling stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) teQ <= 1'b0;
    else       teQ <= teIn;
  end

  // one saturating run-length counter per active level
  for (genvar g = 0; g < NCH; g++) begin : gChan
    logic [CNT_W-1:0] lenQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lenQ <= '0;
      end else if (teQ == actLvl[g]) begin
        if (lenQ != CNT_MAX) lenQ <= lenQ + CNT_W'(1);
      end else begin
        lenQ <= '0;
      end
    end

    assign runLen[g]   = lenQ;
    assign pulseEnd[g] = (teQ != actLvl[g]) && (lenQ != '0);
  end

  // classification at the end of each run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evt <= '0;
    end else begin
      evt.vsEvt <= pulseEnd[CH_VS] && (runLen[CH_VS] >= vsWidth);
      evt.hsEvt <= pulseEnd[CH_HS] && (runLen[CH_HS] >= hsWidth)
                   && (runLen[CH_HS] < vsWidth);
    end
  end

endmodule

// File: rtl/te_trig_ctrl.sv
`timescale 1ns/1ps
module te_trig_ctrl
  import te_sync_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferEn,
  input  logic [1:0]        trigMode,
  input  logic [LINE_W-1:0] lineNum,
  input  teEvt_t            evt,
  output logic              startStrobe
);

  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  trigSel_e          modeSel;
  logic              done;
  logic              seenVs;
  logic [LINE_W-1:0] lineCnt;
  logic [LINE_W-1:0] lineInc;
  logic              fire;
  logic              fireOk;

  assign modeSel = trigSel_e'(trigMode);
  assign lineInc = (lineCnt == LINE_MAX) ? lineCnt : lineCnt + LINE_W'(1);

  always_comb begin
    case (modeSel)
      TRIG_INTERNAL: fire = 1'b1;
      TRIG_FRAME:    fire = evt.vsEvt;
      TRIG_LINE:     fire = (evt.vsEvt && (lineNum == '0)) ||
                            (evt.hsEvt && !evt.vsEvt && seenVs && (lineInc == lineNum));
      default:       fire = 1'b0;
    endcase
  end

  assign fireOk = xferEn && !done && fire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done        <= 1'b0;
      seenVs      <= 1'b0;
      lineCnt     <= '0;
      startStrobe <= 1'b0;
    end else if (!xferEn) begin
      done        <= 1'b0;
      seenVs      <= 1'b0;
      lineCnt     <= '0;
      startStrobe <= 1'b0;
    end else begin
      startStrobe <= fireOk;
      if (fireOk) done <= 1'b1;
      if (evt.vsEvt) begin
        seenVs  <= 1'b1;
        lineCnt <= '0;
      end else if (evt.hsEvt && seenVs) begin
        lineCnt <= lineInc;
      end
    end
  end

endmodule

// File: rtl/te_sync_trigger.sv
`timescale 1ns/1ps
module te_sync_trigger
  import te_sync_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              teIn,
  input  logic              vsPolDef,
  input  logic              hsPolDef,
  input  logic [1:0]        trigMode,
  input  logic [CNT_W-1:0]  hsWidth,
  input  logic [CNT_W-1:0]  vsWidth,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              xferEn,
  output logic              startStrobe
);

  teEvt_t evt;

  te_pulse_meas #(.CNT_W(CNT_W)) u_meas (
    .clk      (clk),
    .rstN     (rstN),
    .teIn     (teIn),
    .vsPolDef (vsPolDef),
    .hsPolDef (hsPolDef),
    .hsWidth  (hsWidth),
    .vsWidth  (vsWidth),
    .evt      (evt)
  );

  te_trig_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .xferEn      (xferEn),
    .trigMode    (trigMode),
    .lineNum     (lineNum),
    .evt         (evt),
    .startStrobe (startStrobe)
  );

endmodule

// File: rtl/te_sync_trigger_chk.sv
`timescale 1ns/1ps
module te_sync_trigger_chk
  import te_sync_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       xferEn,
  input logic [1:0] trigMode,
  input logic       startStrobe,
  input teEvt_t     evt
);

  // R2: internal source fires on the edge after the enable rises
  p_internal_fire_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(xferEn) && trigMode == 2'd0) |=> startStrobe);

  // R3: a pulse is never both kinds
  p_evt_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(evt.vsEvt && evt.hsEvt));

  // R4: frame mode strobe is caused by a frame pulse
  p_frame_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    (startStrobe && $past(trigMode) == 2'd1) |-> $past(evt.vsEvt));

  // R7: each strobe lasts one cycle
  p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |=> !startStrobe);

  // R8: no strobe after an edge that saw the enable low
  p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |-> $past(xferEn));

  // R10: reserved source never fires
  p_reserved_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |-> ($past(trigMode) != 2'd3));

endmodule

bind te_sync_trigger te_sync_trigger_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .xferEn      (xferEn),
  .trigMode    (trigMode),
  .startStrobe (startStrobe),
  .evt         (evt)
);

// File: tb/tb_te_sync_trigger.sv
`timescale 1ns/1ps
module tb_te_sync_trigger;

  localparam int CW = 5;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          teIn = 1'b0;
  logic          vsPolDef = 1'b1;
  logic          hsPolDef = 1'b1;
  logic [1:0]    trigMode = 2'd0;
  logic [CW-1:0] hsWidth = 5'd3;
  logic [CW-1:0] vsWidth = 5'd6;
  logic [LW-1:0] lineNum = '0;
  logic          xferEn = 1'b0;
  logic          startStrobe;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int strobeCnt = 0;
  int lastStrobe = -1;

  te_sync_trigger #(.CNT_W(CW), .LINE_W(LW)) dut (
    .clk(clk), .rstN(rstN), .teIn(teIn), .vsPolDef(vsPolDef), .hsPolDef(hsPolDef),
    .trigMode(trigMode), .hsWidth(hsWidth), .vsWidth(vsWidth), .lineNum(lineNum),
    .xferEn(xferEn), .startStrobe(startStrobe)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (startStrobe === 1'b1) begin
      strobeCnt++;
      lastStrobe = cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] mode, input int hw, input int vw,
                       input int ln, input logic pol);
    @(negedge clk);
    xferEn   = 1'b0;
    trigMode = mode;
    hsWidth  = CW'(hw);
    vsWidth  = CW'(vw);
    lineNum  = LW'(ln);
    vsPolDef = pol;
    hsPolDef = pol;
    teIn     = ~pol;
    repeat (8) @(negedge clk);
    strobeCnt  = 0;
    lastStrobe = -1;
  endtask

  task automatic enable();
    @(negedge clk);
    xferEn = 1'b1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected strobe cycle: two edges after the first inactive sample
  function automatic int strobeAt(input int startCyc, input int len);
    return startCyc + len + 3;
  endfunction

  task automatic pulse(input int n, input int gap, output int e);
    int c;
    @(negedge clk);
    c = cyc;
    teIn = vsPolDef;
    repeat (n) @(negedge clk);
    teIn = ~vsPolDef;
    repeat (gap) @(negedge clk);
    e = strobeAt(c, n);
  endtask

  initial begin
    int c, e, ex;
    void'($urandom(32'd2024));

    // R1 reset
    settle(3);
    chk("R1 strobe in reset", int'(startStrobe), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 strobe after release", int'(startStrobe), 0);

    // R2 internal source, R7 once per enable
    setup(2'd0, 3, 6, 0, 1'b1);
    @(negedge clk); c = cyc; xferEn = 1'b1;
    settle(6);
    chk("R2 internal count", strobeCnt, 1);
    chk("R2 internal cycle", lastStrobe, c + 1);
    settle(20);
    chk("R7 single per enable", strobeCnt, 1);
    @(negedge clk); xferEn = 1'b0;
    settle(2);
    @(negedge clk); c = cyc; xferEn = 1'b1;
    settle(4);
    chk("R7 re-enable count", strobeCnt, 2);
    chk("R7 re-enable cycle", lastStrobe, c + 1);

    // R3 classification, R4 frame mode
    setup(2'd1, 3, 6, 0, 1'b1);
    enable();
    pulse(2, 4, e);
    pulse(4, 4, e);
    pulse(5, 4, e);
    settle(4);
    chk("R3 glitch and line pulses ignored", strobeCnt, 0);
    pulse(6, 4, ex);
    settle(3);
    chk("R4 frame count", strobeCnt, 1);
    chk("R4 frame cycle", lastStrobe, ex);
    pulse(9, 4, e);
    settle(3);
    chk("R7 second frame no strobe", strobeCnt, 1);

    // R3 saturation at counter maximum
    setup(2'd1, 2, 31, 0, 1'b1);
    enable();
    pulse(30, 4, e);
    settle(3);
    chk("R3 below max width ignored", strobeCnt, 0);
    pulse(40, 4, ex);
    settle(3);
    chk("R3 saturated run count", strobeCnt, 1);
    chk("R3 saturated run cycle", lastStrobe, ex);

    // R5 / R6 line mode
    setup(2'd2, 3, 8, 2, 1'b1);
    enable();
    pulse(4, 4, e);
    pulse(4, 4, e);
    settle(3);
    chk("R6 lines before frame ignored", strobeCnt, 0);
    pulse(8, 4, e);
    pulse(4, 4, e);
    settle(3);
    chk("R5 no strobe before line count", strobeCnt, 0);
    pulse(5, 4, ex);
    settle(3);
    chk("R5 line count strobe", strobeCnt, 1);
    chk("R5 line count cycle", lastStrobe, ex);
    pulse(8, 4, e);
    for (int i = 0; i < 3; i++) pulse(4, 4, e);
    chk("R7 line mode single", strobeCnt, 1);

    // R5 line zero
    setup(2'd2, 3, 8, 0, 1'b1);
    enable();
    pulse(4, 4, e);
    pulse(9, 4, ex);
    settle(3);
    chk("R5 line zero count", strobeCnt, 1);
    chk("R5 line zero cycle", lastStrobe, ex);

    // R6 restart on new frame pulse
    setup(2'd2, 3, 8, 2, 1'b1);
    enable();
    pulse(8, 4, e);
    pulse(4, 4, e);
    pulse(8, 4, e);
    pulse(4, 4, e);
    settle(3);
    chk("R6 count restarted", strobeCnt, 0);
    pulse(4, 4, ex);
    settle(3);
    chk("R6 restart strobe cycle", lastStrobe, ex);

    // R8 cancel
    setup(2'd2, 3, 8, 2, 1'b1);
    enable();
    pulse(8, 4, e);
    pulse(4, 4, e);
    @(negedge clk); xferEn = 1'b0;
    settle(3);
    enable();
    for (int i = 0; i < 3; i++) pulse(4, 4, e);
    settle(3);
    chk("R8 pending cleared", strobeCnt, 0);
    pulse(8, 4, e);
    pulse(4, 4, e);
    pulse(4, 4, ex);
    settle(3);
    chk("R8 count after re-enable", strobeCnt, 1);
    chk("R8 cycle after re-enable", lastStrobe, ex);

    // R9 inverted polarity, idle high
    setup(2'd1, 3, 6, 0, 1'b0);
    enable();
    pulse(4, 4, e);
    pulse(7, 4, ex);
    settle(3);
    chk("R9 inverted count", strobeCnt, 1);
    chk("R9 inverted cycle", lastStrobe, ex);

    // R10 reserved mode
    setup(2'd3, 3, 6, 0, 1'b1);
    enable();
    pulse(7, 4, e);
    pulse(4, 4, e);
    settle(4);
    chk("R10 reserved silent", strobeCnt, 0);

    // R4 / R3 random exact-width boundary in frame mode
    for (int k = 0; k < 4; k++) begin
      int hw, vw;
      hw = 2 + int'($urandom % 4);
      vw = hw + 1 + int'($urandom % 8);
      setup(2'd1, hw, vw, 0, 1'b1);
      enable();
      pulse(vw - 1, 4, e);
      pulse(vw, 4, ex);
      settle(3);
      chk("R4 boundary count", strobeCnt, 1);
      chk("R4 boundary cycle", lastStrobe, ex);
    end

    // R5 random line mode with glitches
    for (int k = 0; k < 8; k++) begin
      int hw, vw, ln;
      hw = 2 + int'($urandom % 4);
      vw = hw + 2 + int'($urandom % 5);
      ln = int'($urandom % 4);
      setup(2'd2, hw, vw, ln, 1'b1);
      enable();
      pulse(hw, 3, e);
      pulse(vw + int'($urandom % 3), 3, ex);
      for (int i = 1; i <= ln + 1; i++) begin
        pulse(1 + int'($urandom % (hw - 1)), 3, e);
        pulse(hw + int'($urandom % (vw - hw)), 3, e);
        if (i == ln) ex = e;
      end
      settle(4);
      chk("R5 random count", strobeCnt, 1);
      chk("R5 random cycle", lastStrobe, ex);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule